// File: doc/BRIEF.md
# Node Address Permutation Unit

This block maps an n-bit node address of an interconnection network with N = 2^n nodes to the address of the node it connects to. One of several routing functions is applied: complement a single bit, rotate left, swap the end bits, reverse the bit order, or step forward or back by a power of two modulo N. Rotate, swap and reverse can act on the whole address or only on a subfield of k bits, taken either at the bottom of the address or at the top.

Each request supplies an address, a 4-bit function code and one small operand. That operand is the bit index i for the single-bit and power-of-two functions, and the field width k for the subfield functions. The result is registered and appears one clock after the request, with a valid flag. If an operand is out of range or the code is undefined, the address passes through unchanged and an error flag is raised. A new request can be accepted on every clock.

Top module: `perm_unit`

## Requirements
- R1: Code 1 complements address bit i (operand) and leaves every other bit as it was.
- R2: Code 2 rotates the whole address left by one bit, so bit n-1 moves to bit 0. The operand is ignored and no error is raised.
- R3: Code 3 rotates only the low k bits left by one, so bit k-1 moves to bit 0. Code 4 rotates only the top k bits left by one, so bit n-1 moves to bit n-k. All bits outside the field keep their values.
- R4: Code 5 swaps bit n-1 with bit 0 and ignores the operand. Code 6 swaps bit k-1 with bit 0. Code 7 swaps bit n-1 with bit n-k.
- R5: Code 8 reverses the order of all bits and ignores the operand. Code 9 reverses the bit order inside the low k bits, and code 10 does the same inside the top k bits.
- R6: Code 11 gives (x + 2^i) mod N and code 12 gives (x - 2^i) mod N. Both wrap around at the ends of the range.
- R7: For codes 1, 11 and 12 an operand i >= n is invalid. For codes 3, 4, 6, 7, 9 and 10 a width k = 0 or k > n is invalid. An invalid operand gives the input address unchanged with the error flag set. A valid request clears the error flag.
- R8: Code 0 passes the address through with no error. Codes 13 to 15 pass it through with the error flag set.
- R9: The result of a request appears exactly one clock after it. out_valid follows in_valid with a one-cycle delay, and requests on consecutive clocks each give their own result.
- R10: While in_valid is low, out_addr and out_err keep the value of the last result.
- R11: During reset out_valid, out_addr and out_err are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| in_func | input | 4 | Function code |
| in_addr | input | ADDR_W | Source node address |
| in_prm | input | $clog2(ADDR_W+1) | Bit index i or field width k |
| out_valid | output | 1 | Result strobe, one clock after in_valid |
| out_addr | output | ADDR_W | Destination node address |
| out_err | output | 1 | Operand or code was invalid |

## Verification
Every result, including the error flag, is due on the first rising edge after its request. The bench drives a request on a falling edge and reads the matching result on the next falling edge, just before it drives the following request. This lets back-to-back requests each be checked against their own expected value. On idle cycles the bench checks at that same falling edge that the last result is still held. The reset values are read while reset is still asserted.

// File: rtl/perm_pkg.sv
package perm_pkg;

   typedef enum logic [3:0] {
      FN_PASS    = 4'd0,
      FN_CUBE    = 4'd1,
      FN_SHUF    = 4'd2,
      FN_SHUF_LO = 4'd3,
      FN_SHUF_HI = 4'd4,
      FN_BFLY    = 4'd5,
      FN_BFLY_LO = 4'd6,
      FN_BFLY_HI = 4'd7,
      FN_REV     = 4'd8,
      FN_REV_LO  = 4'd9,
      FN_REV_HI  = 4'd10,
      FN_PLUS    = 4'd11,
      FN_MINUS   = 4'd12
   } perm_fn_e;

   localparam int FN_LAST = 12;

endpackage

// File: rtl/perm_field.sv
// Subfield rotate / end-swap / reverse on the low or high k bits.
module perm_field #(
   parameter int W    = 4,
   parameter int KW   = 3,
   parameter bit HIGH = 1'b0
) (
   input  logic [W-1:0]  x,
   input  logic [KW-1:0] k,
   output logic [W-1:0]  rot,
   output logic [W-1:0]  swp,
   output logic [W-1:0]  rev
);
   localparam int IW = (W > 1) ? $clog2(W) : 1;

   generate
      if (HIGH) begin : g_hi
         always_comb begin
            automatic int kk   = (int'(k) > W) ? W : int'(k);
            automatic int base = W - kk;
            rot = x;
            swp = x;
            rev = x;
            for (int j = 0; j < W - 1; j++) begin
               if (j >= base) rot[j+1] = x[j];
            end
            for (int j = 0; j < W; j++) begin
               if (j >= base) rev[j] = x[IW'(W - 1 + base - j)];
            end
            if (kk >= 1) begin
               rot[IW'(base)] = x[W-1];
               swp[W-1]       = x[IW'(base)];
               swp[IW'(base)] = x[W-1];
            end
         end
      end else begin : g_lo
         always_comb begin
            automatic int kk = (int'(k) > W) ? W : int'(k);
            rot = x;
            swp = x;
            rev = x;
            for (int j = 1; j < W; j++) begin
               if (j < kk) rot[j] = x[j-1];
            end
            for (int j = 0; j < W; j++) begin
               if (j < kk) rev[j] = x[IW'(kk - 1 - j)];
            end
            if (kk >= 1) begin
               rot[0]           = x[IW'(kk - 1)];
               swp[0]           = x[IW'(kk - 1)];
               swp[IW'(kk - 1)] = x[0];
            end
         end
      end
   endgenerate
endmodule

// File: rtl/perm_step.sv
// Single-bit complement and power-of-two step modulo 2^W.
module perm_step #(
   parameter int W  = 4,
   parameter int KW = 3
) (
   input  logic [W-1:0]  x,
   input  logic [KW-1:0] i,
   output logic [W-1:0]  flip,
   output logic [W-1:0]  plus,
   output logic [W-1:0]  minus
);
   logic [W-1:0] step;

   assign step  = {{(W-1){1'b0}}, 1'b1} << i;
   assign flip  = x ^ step;
   assign plus  = x + step;
   assign minus = x - step;
endmodule

// File: rtl/perm_unit.sv
module perm_unit #(
   parameter int ADDR_W = 4,
   localparam int PW    = $clog2(ADDR_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [3:0]        in_func,
   input  logic [ADDR_W-1:0] in_addr,
   input  logic [PW-1:0]     in_prm,
   output logic              out_valid,
   output logic [ADDR_W-1:0] out_addr,
   output logic              out_err
);
   import perm_pkg::*;

   generate
      if (ADDR_W < 2 || ADDR_W > 16) begin : g_bad_width
         $error("perm_unit: ADDR_W must lie in 2..16");
      end
   endgenerate

   logic [ADDR_W-1:0] lo_rot, lo_swp, lo_rev;
   logic [ADDR_W-1:0] hi_rot, hi_swp, hi_rev;
   logic [ADDR_W-1:0] full_rot, full_swp, full_rev;
   logic [ADDR_W-1:0] st_flip, st_plus, st_minus;
   logic [ADDR_W-1:0] nxt_addr;
   logic              nxt_err;
   logic              k_bad, i_bad;

   perm_field #(.W(ADDR_W), .KW(PW), .HIGH(1'b0)) u_lo (
      .x(in_addr), .k(in_prm), .rot(lo_rot), .swp(lo_swp), .rev(lo_rev));

   perm_field #(.W(ADDR_W), .KW(PW), .HIGH(1'b1)) u_hi (
      .x(in_addr), .k(in_prm), .rot(hi_rot), .swp(hi_swp), .rev(hi_rev));

   // whole-address forms: the low field with k = ADDR_W
   perm_field #(.W(ADDR_W), .KW(PW), .HIGH(1'b0)) u_full (
      .x(in_addr), .k(PW'(ADDR_W)), .rot(full_rot), .swp(full_swp), .rev(full_rev));

   perm_step #(.W(ADDR_W), .KW(PW)) u_step (
      .x(in_addr), .i(in_prm), .flip(st_flip), .plus(st_plus), .minus(st_minus));

   assign k_bad = (in_prm == '0) || (in_prm > PW'(ADDR_W));
   assign i_bad = (in_prm >= PW'(ADDR_W));

   always_comb begin
      nxt_addr = in_addr;
      nxt_err  = 1'b0;
      case (in_func)
         FN_PASS:    nxt_addr = in_addr;
         FN_CUBE:    if (i_bad) nxt_err = 1'b1; else nxt_addr = st_flip;
         FN_SHUF:    nxt_addr = full_rot;
         FN_SHUF_LO: if (k_bad) nxt_err = 1'b1; else nxt_addr = lo_rot;
         FN_SHUF_HI: if (k_bad) nxt_err = 1'b1; else nxt_addr = hi_rot;
         FN_BFLY:    nxt_addr = full_swp;
         FN_BFLY_LO: if (k_bad) nxt_err = 1'b1; else nxt_addr = lo_swp;
         FN_BFLY_HI: if (k_bad) nxt_err = 1'b1; else nxt_addr = hi_swp;
         FN_REV:     nxt_addr = full_rev;
         FN_REV_LO:  if (k_bad) nxt_err = 1'b1; else nxt_addr = lo_rev;
         FN_REV_HI:  if (k_bad) nxt_err = 1'b1; else nxt_addr = hi_rev;
         FN_PLUS:    if (i_bad) nxt_err = 1'b1; else nxt_addr = st_plus;
         FN_MINUS:   if (i_bad) nxt_err = 1'b1; else nxt_addr = st_minus;
         default:    nxt_err = 1'b1;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_addr  <= '0;
         out_err   <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_addr <= nxt_addr;
            out_err  <= nxt_err;
         end
      end
   end
endmodule

// File: rtl/perm_unit_chk.sv
module perm_unit_chk #(
   parameter int ADDR_W = 4,
   parameter int PW     = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [3:0]        in_func,
   input logic [ADDR_W-1:0] in_addr,
   input logic [PW-1:0]     in_prm,
   input logic              out_valid,
   input logic [ADDR_W-1:0] out_addr,
   input logic              out_err
);
   // R9
   valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   // R9
   idle_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   // R10
   hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(out_addr) && $stable(out_err)));
   // R8
   undef_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_func > 4'd12) |=> (out_err && out_addr == $past(in_addr)));
   // R7
   err_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (!out_err || out_addr == $past(in_addr)));
   // R1
   cube_one_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_func == 4'd1 && in_prm < PW'(ADDR_W))
      |=> (!out_err && $countones(out_addr ^ $past(in_addr)) == 1));
   // R5
   perm_weight_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_func >= 4'd2 && in_func <= 4'd10)
      |=> ($countones(out_addr) == $countones($past(in_addr))));
   // R2
   full_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (in_func == 4'd2 || in_func == 4'd5 || in_func == 4'd8))
      |=> !out_err);
endmodule

bind perm_unit perm_unit_chk #(.ADDR_W(ADDR_W), .PW(PW)) u_perm_unit_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_func(in_func),
   .in_addr(in_addr), .in_prm(in_prm), .out_valid(out_valid),
   .out_addr(out_addr), .out_err(out_err));

// File: tb/test_perm_unit.sv
module test_perm_unit;
   localparam int W  = 6;
   localparam int PW = $clog2(W + 1);
   localparam int N  = 1 << W;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [3:0]    in_func = '0;
   logic [W-1:0]  in_addr = '0;
   logic [PW-1:0] in_prm = '0;
   logic          out_valid;
   logic [W-1:0]  out_addr;
   logic          out_err;

   int n_chk = 0;
   int n_bad = 0;

   bit      pend_on = 1'b0;
   bit      pend_v  = 1'b0;
   int      pend_a  = 0;
   bit      pend_e  = 1'b0;
   string   pend_r  = "R11";

   always #10 clk = ~clk;

   perm_unit #(.ADDR_W(W)) i_perm_unit (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_func(in_func),
      .in_addr(in_addr), .in_prm(in_prm), .out_valid(out_valid),
      .out_addr(out_addr), .out_err(out_err));

   function automatic int rot_f(int f, int len);
      int m = (1 << len) - 1;
      return ((f << 1) | (f >> (len - 1))) & m;
   endfunction

   function automatic int swp_f(int f, int len);
      int lo = f & 1;
      int hi = (f >> (len - 1)) & 1;
      int r  = f & ~(1 | (1 << (len - 1)));
      return r | (lo << (len - 1)) | hi;
   endfunction

   function automatic int rev_f(int f, int len);
      int r = 0;
      for (int j = 0; j < len; j++) r = r | (((f >> j) & 1) << (len - 1 - j));
      return r;
   endfunction

   // op: 0 rotate, 1 swap, 2 reverse, on field of len bits starting at lo
   function automatic int field_op(int x, int lo, int len, int op);
      int m = ((1 << len) - 1) << lo;
      int f = (x & m) >> lo;
      int g = (op == 0) ? rot_f(f, len) : (op == 1) ? swp_f(f, len) : rev_f(f, len);
      return (x & ~m & (N - 1)) | (g << lo);
   endfunction

   // returns {err, addr}
   function automatic int model(int fn, int x, int p);
      bit kb = (p == 0) || (p > W);
      bit ib = (p >= W);
      case (fn)
         0:  return x;
         1:  return ib ? (N | x) : (x ^ (1 << p));
         2:  return field_op(x, 0, W, 0);
         3:  return kb ? (N | x) : field_op(x, 0, p, 0);
         4:  return kb ? (N | x) : field_op(x, W - p, p, 0);
         5:  return field_op(x, 0, W, 1);
         6:  return kb ? (N | x) : field_op(x, 0, p, 1);
         7:  return kb ? (N | x) : field_op(x, W - p, p, 1);
         8:  return field_op(x, 0, W, 2);
         9:  return kb ? (N | x) : field_op(x, 0, p, 2);
         10: return kb ? (N | x) : field_op(x, W - p, p, 2);
         11: return ib ? (N | x) : ((x + (1 << p)) & (N - 1));
         12: return ib ? (N | x) : ((x - (1 << p)) & (N - 1));
         default: return N | x;
      endcase
   endfunction

   function automatic string req_of(int fn, int p);
      bit kb = (p == 0) || (p > W);
      bit ib = (p >= W);
      case (fn)
         1, 11, 12: if (ib) return "R7";
         3, 4, 6, 7, 9, 10: if (kb) return "R7";
         default: ;
      endcase
      case (fn)
         1: return "R1";
         2: return "R2";
         3, 4: return "R3";
         5, 6, 7: return "R4";
         8, 9, 10: return "R5";
         11, 12: return "R6";
         default: return "R8";
      endcase
   endfunction

   task automatic check(string r, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
      end
   endtask

   // one cycle: check the result of the previous cycle, then drive the next request
   task automatic cyc(bit v, int fn, int x, int p);
      @(negedge clk);
      if (pend_on) begin
         check("R9", int'(out_valid), int'(pend_v));
         check(pend_r, {out_err, out_addr}, {pend_e, pend_a[W-1:0]});
      end
      in_valid = v;
      in_func  = 4'(fn);
      in_addr  = W'(x);
      in_prm   = PW'(p);
      pend_on  = 1'b1;
      pend_v   = v;
      if (v) begin
         int m = model(fn, x, p);
         pend_a = m & (N - 1);
         pend_e = (m >> W) & 1;
         pend_r = req_of(fn, p);
      end else begin
         pend_r = "R10";
      end
   endtask

   initial begin : watchdog
      #(20 * 200000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      int seed = 32'h5eed;
      void'($urandom(seed));
      repeat (3) @(negedge clk);
      // R11 reset state, even with a request pending
      in_valid = 1'b1;
      in_func  = 4'd2;
      in_addr  = 6'h2a;
      @(negedge clk);
      check("R11", {out_valid, out_err, out_addr}, 0);
      in_valid = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;

      cyc(1, 1, 6'b101010, 0);   // R1 -> 101011
      cyc(1, 1, 6'b101010, 5);   // R1 -> 001010
      cyc(1, 2, 6'b100001, 3);   // R2 operand ignored
      cyc(1, 3, 6'b110101, 3);   // R3 low 3
      cyc(1, 3, 6'b110101, 1);   // R3 k=1 identity
      cyc(1, 4, 6'b101100, 3);   // R3 high 3
      cyc(1, 4, 6'b100000, 6);   // R3 k=n
      cyc(1, 5, 6'b100000, 0);   // R4
      cyc(1, 6, 6'b001011, 4);   // R4
      cyc(1, 7, 6'b010001, 5);   // R4
      cyc(1, 8, 6'b110100, 7);   // R5 operand ignored
      cyc(1, 9, 6'b000110, 4);   // R5
      cyc(1, 10, 6'b110001, 2);  // R5
      cyc(1, 11, 63, 0);         // R6 wrap -> 0
      cyc(1, 12, 0, 5);          // R6 wrap -> 32
      cyc(1, 11, 40, 5);         // R6 -> 8
      cyc(1, 3, 21, 0);          // R7 k=0
      cyc(1, 9, 21, 7);          // R7 k>n
      cyc(1, 1, 21, 6);          // R7 i=n
      cyc(1, 12, 9, 7);          // R7
      cyc(1, 0, 37, 3);          // R8 pass, error cleared
      cyc(1, 14, 37, 2);         // R8 undefined
      cyc(0, 2, 5, 1);           // R10 idle: error result held
      cyc(0, 1, 6, 0);           // R10
      cyc(1, 15, 11, 0);         // R8

      for (int t = 0; t < 400; t++) begin
         int fn = $urandom_range(0, 15);
         cyc(($urandom_range(0, 4) != 0), fn, $urandom_range(0, N - 1),
             $urandom_range(0, (1 << PW) - 1));
      end
      cyc(0, 0, 0, 0);
      @(negedge clk);
      check("R9", int'(out_valid), 0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule